// File: doc/BRIEF.md
# Multi-Rate Ten-Bit Transmit Serializer

This block turns a stream of already-encoded 10-bit transmission characters into one serial bit stream for a single transmit lane. It runs entirely on a fast bit clock that stands in for the synthesized oscillator clock. From that clock it derives a word-rate clock for the upstream logic and a one-cycle load strobe that marks the edge on which the next character is taken.

A half-rate control stretches every serial bit to two fast-clock cycles. It is sampled only when a new character is loaded, so a character is never sent at two different rates. A reference-ratio input says whether the reference runs at one tenth or one twentieth of the serial rate. The outputs never depend on it: the word clock always spans exactly ten serial bit periods. Characters are expected to be DC-balanced 8B/10B codes and pass through unchanged. Several lanes that share one bit clock and reset load on the same word boundary.

Top module: `tx_serializer`

## Requirements
- R1: The 10-bit value on `word_i` at the load edge is sent unchanged as ten consecutive serial bits.
- R2: Bit 0 of the captured word is sent first and bit 9 is sent last.
- R3: `word_clk_o` is high during serial bits 0 to 4 of each word and low during bits 5 to 9, so its period is ten serial bit periods.
- R4: With `rate_half_i` low at the load edge, each serial bit of that word lasts one fast-clock cycle.
- R5: With `rate_half_i` high at the load edge, each serial bit of that word lasts two fast-clock cycles.
- R6: `ref_div20_i` (0 = reference at 1/10 of the serial rate, 1 = at 1/20) has no effect on any output.
- R7: `load_o` is high for exactly one fast-clock cycle per word, namely the last fast cycle of bit 9. `word_i` is captured on the rising edge that ends that cycle.
- R8: During reset and until the first load, `ser_o` and `word_clk_o` are 0. `load_o` is high in the first cycle after reset is released, so the first word is captured at that cycle's closing edge.
- R9: `rate_half_i` is sampled only at the load edge. Changes in the middle of a word do not alter the bit timing of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_half_i | input | 1 | 1 = each serial bit held for two fast cycles |
| ref_div20_i | input | 1 | Reference ratio setting: 0 = 1/10, 1 = 1/20 of the serial rate |
| word_i | input | 10 | Encoded character from the upstream FIFO |
| ser_o | output | 1 | Serial data bit |
| word_clk_o | output | 1 | Word-rate clock for the upstream logic |
| load_o | output | 1 | One-cycle strobe; `word_i` is captured at the closing edge |

## Verification
The assertions check on every cycle that the load strobe never lasts two cycles, that the word clock rises just after a load and is low while the load is pending, that the captured word equals the presented one, that the active rate holds between loads, and that idle half-rate cycles leave the outputs unchanged even when the reference setting toggles. Only the bench's scenarios can show the full bit order and bit durations of whole characters, the zero output before the first load, and that changing the rate mid-word or changing the reference setting leaves the serial stream identical to the reference model. Those scenarios run under randomly changing words, rates and reference settings.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;
  localparam int unsigned WORD_W_DEF = 10;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_half_i,
  input  logic load_i,
  output logic bit_en_o,
  output logic rate_o
);
  logic rate_q, div_q;

  // rate latched only at a word boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= 1'b0;
      div_q  <= 1'b0;
    end else if (load_i) begin
      rate_q <= rate_half_i;
      div_q  <= 1'b0;
    end else if (rate_q) begin
      div_q  <= ~div_q;
    end
  end

  assign bit_en_o = ~rate_q | div_q;
  assign rate_o   = rate_q;

  p_rate_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(rate_o));
endmodule

// File: rtl/tx_word_counter.sv
module tx_word_counter #(
  parameter int unsigned WORD_W = tx_ser_pkg::WORD_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  output logic load_o,
  output logic word_clk_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HALF_M = CNT_W'(WORD_W / 2 - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wclk_q;
  logic             last;

  assign last   = (cnt_q == LAST);
  assign load_o = bit_en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= LAST;
      wclk_q <= 1'b0;
    end else if (bit_en_i) begin
      if (last) begin
        cnt_q  <= '0;
        wclk_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == HALF_M) wclk_q <= 1'b0;
      end
    end
  end

  assign word_clk_o = wclk_q;

  p_load_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  p_wclk_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> word_clk_o);
  p_wclk_low_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> !word_clk_o);
endmodule

// File: rtl/tx_shift_reg.sv
module tx_shift_reg #(
  parameter int unsigned WORD_W = tx_ser_pkg::WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o
);
  logic [WORD_W-1:0] sh_q;

  // LSB leaves first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[WORD_W-1:1]};
  end

  assign ser_o = sh_q[0];

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sh_q == $past(word_i));
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int unsigned WORD_W = tx_ser_pkg::WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_half_i,
  input  logic              ref_div20_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ser_o,
  output logic              word_clk_o,
  output logic              load_o
);
  logic bit_en, rate_act, load;

  tx_bit_timer i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_half_i(rate_half_i),
    .load_i     (load),
    .bit_en_o   (bit_en),
    .rate_o     (rate_act)
  );

  tx_word_counter #(.WORD_W(WORD_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en),
    .load_o    (load),
    .word_clk_o(word_clk_o)
  );

  tx_shift_reg #(.WORD_W(WORD_W)) i_sh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(bit_en),
    .word_i (word_i),
    .ser_o  (ser_o)
  );

  assign load_o = load;

  p_idle_ref_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en && rate_act && ref_div20_i != $past(ref_div20_i))
      |=> ($stable(ser_o) && $stable(word_clk_o)));
endmodule

// File: tb/test_tx_serializer.sv
module test_tx_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_half = 1'b0;
  logic ref_div20 = 1'b0;
  logic [W-1:0] word = '0;
  logic ser, wclk, load;

  int checks = 0;
  int errors = 0;

  bit          started = 0;
  int          p = 0;
  int          cur_d = 1;
  logic [W-1:0] cur_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_serializer i_tx_serializer (
    .clk_i(clk), .rst_ni(rst_n), .rate_half_i(rate_half), .ref_div20_i(ref_div20),
    .word_i(word), .ser_o(ser), .word_clk_o(wclk), .load_o(load)
  );

  function automatic logic exp_ser();
    if (!started) return 1'b0;
    return cur_word[p / cur_d];
  endfunction
  function automatic logic exp_wclk();
    if (!started) return 1'b0;
    return (p / cur_d) < W / 2;
  endfunction
  function automatic logic exp_load();
    if (!started) return 1'b1;
    return p == W * cur_d - 1;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [W-1:0] w, input logic r, input logic rf, input string tag);
    string ts, tl, tw;
    bit el;
    ts = !started ? "R8" : (cur_d == 2 ? "R5 R2" : "R4 R2");
    tl = !started ? "R8" : "R7";
    tw = !started ? "R8" : "R3";
    if (tag != "") begin ts = tag; tl = tag; tw = tag; end
    el = exp_load();
    chk(ser, exp_ser(), ts, "ser_o");
    chk(wclk, exp_wclk(), tw, "word_clk_o");
    chk(load, el, tl, "load_o");
    word = w; rate_half = r; ref_div20 = rf;
    if (el) begin
      started = 1; cur_word = w; cur_d = r ? 2 : 1; p = 0;
    end else p++;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R7 actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] dir_w [5];
    void'($urandom(32'd7));
    dir_w[0] = 10'h3FF; dir_w[1] = 10'h155; dir_w[2] = 10'h001;
    dir_w[3] = 10'h200; dir_w[4] = 10'h0F8;
    word = 10'h2AA;
    repeat (3) begin
      @(negedge clk);
      chk(ser, 1'b0, "R8", "ser_o in reset");
      chk(wclk, 1'b0, "R8", "word_clk_o in reset");
    end
    rst_n = 1'b1;
    // directed words at both rates; R1 passthrough of fixed patterns
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < 5; i++)
        for (int k = 0; k < 45; k++) step(dir_w[i], r[0], 1'b0, "");
    for (int k = 0; k < 60; k++) step(10'h17C, 1'b0, 1'b0, "R1");
    // R9: rate toggles every cycle
    for (int k = 0; k < 600; k++) step(W'($urandom), k[0], 1'b0, "R9");
    // R6: reference setting toggles every cycle
    for (int k = 0; k < 600; k++) step(W'($urandom), (k / 37) % 2 == 1, k[0], "R6");
    // random mix
    for (int k = 0; k < 4000; k++)
      step(W'($urandom), 1'($urandom), 1'($urandom), "");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule